// File: doc/BRIEF.md
# Two-Channel Glitch-Free Clock Switch

This block chooses which of two unrelated clocks drives a single output clock, and it changes that choice without producing a runt pulse or a clipped phase. A level on `sel` names the wanted channel. When the wanted channel differs from the live one, the switch does three things in order:

- It shuts off the live channel on that channel's falling edge.
- It waits until that shut-off has been seen in its control domain.
- It enables the other channel, but only after that channel has supplied a fixed run of rising edges while the output stays low.

The control logic runs on channel 0's clock, and `sel` is sampled on that clock. If channel 0 stops, no switch can begin or finish. Both channels must be toggling for a switch to complete. The old channel's edges are needed to stop it, and the new channel's edges are needed to start it. `busy` shows that a hand-off is in progress, and `sel_active` names the channel that currently drives the output. The control and status pins are plain levels. There is no data stream and so no valid/ready handshake.

Top module: `gfsw_top`

## Requirements
- R1: After reset, `clk_out` follows channel 0, `busy` is 0 and `sel_active` is 0.
- R2: While `busy` is 0, every rising edge of `clk_out` coincides with a rising edge of the channel named by `sel_active` (0 = `clk_ch0`, 1 = `clk_ch1`).
- R3: The two channels are never gated onto the output at the same moment.
- R4: `sel` is sampled on rising edges of `clk_ch0`. If the switch is idle and `sel` differs from the current target, `busy` goes to 1 on that edge. `busy` stays at 1 until the new channel drives the output. `sel_active` takes the new value on the same edge where `busy` falls.
- R5: When switching away from channel 0, the high phase that begins at the `clk_ch0` edge which captures the request is the last channel-0 pulse on `clk_out`. Exactly one more channel-0 rising edge appears.
- R6: Once the old channel is off, `clk_out` stays low through at least 5 rising edges of the new channel before that channel's first pulse (parameter `ON_WAIT`, default 5).
- R7: Every high phase on `clk_out` is a complete high phase of its source clock. Every low phase lasts at least the shorter of the two half-periods.
- R8: A change of `sel` while `busy` is 1 is held. When the current switch ends, a new switch starts on the next `clk_ch0` edge if `sel` differs from the channel just reached.
- R9: While `clk_ch0` is stopped, no switch starts, `busy` and `sel_active` keep their values, and the output stays on its current channel.
- R10: If either channel stops during a switch, `busy` stays at 1 and `sel_active` keeps its old value. The switch completes once that clock runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ch0 | input | 1 | Channel 0 clock; also clocks the control logic |
| clk_ch1 | input | 1 | Channel 1 clock, asynchronous to channel 0 |
| rst_n | input | 1 | Active-low asynchronous reset, released per domain through a synchroniser |
| sel | input | 1 | Wanted channel, synchronous to `clk_ch0` |
| clk_out | output | 1 | Switched output clock |
| busy | output | 1 | High while a hand-off is in progress |
| sel_active | output | 1 | Channel currently driving `clk_out` |

## Verification
The bench times every edge of `clk_out` against the two source clocks and checks each case below.

- **Clipped or overlapped phases.** A design that gated on a rising edge, or that overlapped the two channels, would show a high phase shorter than its source's half-period. It could also show a rising edge that matches neither source.
- **Shortened quiet gap.** A design with the start-up count off by one would produce fewer than six new-channel rising edges from the last output fall up to and including the first new pulse.
- **Late shut-off.** A design that routed channel 0's shut-off through a synchroniser would leak extra channel-0 pulses after the request.
- **Deferred request.** A design that dropped a `sel` change made while `busy` is high would settle on the wrong channel.
- **Stopped clocks.** A design without the interlock would hand over while a clock is stopped, or report `sel_active` for a channel that is not toggling.

// File: rtl/gfsw_pkg.sv
`timescale 1ns/10ps
package gfsw_pkg;
  localparam int NCH = 2;
  typedef logic [NCH-1:0] chvec_t;
endpackage

// File: rtl/gfsw_sync.sv
`timescale 1ns/10ps
module gfsw_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_l,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gfsw_chan.sv
`timescale 1ns/10ps
module gfsw_chan #(
  parameter int ON_WAIT     = 5,
  parameter int SYNC_STAGES = 2,
  parameter bit SAME_DOMAIN = 1'b0,
  parameter bit START_ON    = 1'b0
) (
  input  logic clk,
  input  logic rst_l,
  input  logic req,
  output logic gate
);
  localparam int CNT_W = $clog2(ON_WAIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ON_WAIT);

  logic             req_s;
  logic [CNT_W-1:0] cnt;

  generate
    if (SAME_DOMAIN) begin : g_direct
      assign req_s = req;
    end else begin : g_sync
      gfsw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(START_ON)) u_req_sync (
        .clk(clk), .rst_l(rst_l), .d(req), .q(req_s)
      );
    end
  endgenerate

  // start-up counter: rising edges seen while the request is held
  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l)                    cnt <= START_ON ? CNT_MAX : '0;
    else if (!req_s)               cnt <= '0;
    else if (cnt != CNT_MAX)       cnt <= cnt + 1'b1;
  end

  // gate updates only on the falling edge, while the clock is low
  always_ff @(negedge clk or negedge rst_l) begin
    if (!rst_l) gate <= START_ON;
    else        gate <= req_s && (cnt == CNT_MAX);
  end

  assign_gate_after_wait_R6: assert property (@(posedge clk) disable iff (!rst_l)
    gate |-> (cnt == CNT_MAX));
endmodule

// File: rtl/gfsw_ctrl.sv
`timescale 1ns/10ps
module gfsw_ctrl
  import gfsw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_l,
  input  logic   sel,
  input  chvec_t gate,
  output chvec_t req,
  output logic   busy,
  output logic   active
);
  chvec_t live_s;
  logic   target;
  logic   landed;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_live
      gfsw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(i == 0)) u_live_sync (
        .clk(clk), .rst_l(rst_l), .d(gate[i]), .q(live_s[i])
      );
    end
  endgenerate

  // a channel may be requested only once the other is seen off
  assign req[0] = (target == 1'b0) && !live_s[1];
  assign req[1] = (target == 1'b1) && !live_s[0];
  assign landed = live_s[target] && !live_s[!target];

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      target <= 1'b0;
      busy   <= 1'b0;
      active <= 1'b0;
    end else if (!busy) begin
      if (sel != target) begin
        target <= sel;
        busy   <= 1'b1;
      end
    end else if (landed) begin
      busy   <= 1'b0;
      active <= target;
    end
  end

  assert_target_hold_R8: assert property (@(posedge clk) disable iff (!rst_l)
    busy |=> $stable(target));
  assert_busy_until_live_R4: assert property (@(posedge clk) disable iff (!rst_l)
    (busy && !live_s[target]) |=> busy);
  assert_idle_live_R2: assert property (@(posedge clk) disable iff (!rst_l)
    !busy |-> (live_s[active] && !live_s[!active]));
endmodule

// File: rtl/gfsw_top.sv
`timescale 1ns/10ps
module gfsw_top
  import gfsw_pkg::*;
#(
  parameter int ON_WAIT     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_ch0,
  input  logic clk_ch1,
  input  logic rst_n,
  input  logic sel,
  output logic clk_out,
  output logic busy,
  output logic sel_active
);
  chvec_t clks;
  chvec_t rst_l;
  chvec_t req;
  chvec_t gate;

  assign clks = {clk_ch1, clk_ch0};

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      gfsw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
        .clk(clks[i]), .rst_l(rst_n), .d(1'b1), .q(rst_l[i])
      );
      gfsw_chan #(
        .ON_WAIT(ON_WAIT), .SYNC_STAGES(SYNC_STAGES),
        .SAME_DOMAIN(i == 0), .START_ON(i == 0)
      ) u_chan (
        .clk(clks[i]), .rst_l(rst_l[i]), .req(req[i]), .gate(gate[i])
      );
    end
  endgenerate

  gfsw_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk_ch0), .rst_l(rst_l[0]), .sel(sel), .gate(gate),
    .req(req), .busy(busy), .active(sel_active)
  );

  assign clk_out = |(clks & gate);

  always_comb begin
    if (rst_l[0]) begin
      assert_one_gate_R3: assert (!(gate[0] && gate[1]));
    end
  end
endmodule

// File: tb/sim_gfsw_top.sv
`timescale 1ns/10ps
module sim_gfsw_top;
  logic clk0 = 1'b0, clk1 = 1'b0, rst_n = 1'b0, sel = 1'b0;
  logic clk_out, busy, sel_active;
  bit   run0 = 1'b1, run1 = 1'b1, mon_on = 1'b0, have_fall = 1'b0;
  int   n_checks = 0, n_fail = 0;
  int   prev_src = -1, cur_src = 0, src;
  int   rises_by[2] = '{0, 0};
  int   since_fall[2] = '{0, 0};
  real  r0 = -100.0, r1 = -100.0, t_rise = 0.0, t_fall = 0.0, t_now;
  real  half[2] = '{2.0, 3.5};

  gfsw_top u0 (.clk_ch0(clk0), .clk_ch1(clk1), .rst_n(rst_n), .sel(sel),
               .clk_out(clk_out), .busy(busy), .sel_active(sel_active));

  // 250 MHz control clock; channel 1 at 7 ns, offset so edges never coincide
  always begin #2.0; if (run0 || clk0) clk0 = ~clk0; end
  initial begin #1.3; forever begin if (run1 || clk1) clk1 = ~clk1; #3.5; end end

  always @(posedge clk0) begin r0 = $realtime; since_fall[0]++; end
  always @(posedge clk1) begin r1 = $realtime; since_fall[1]++; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model of output timing, evaluated on every output edge
  always @(posedge clk_out) begin
    t_now = $realtime;
    #0.1;
    if (mon_on) begin
      if (t_now - r0 < 0.05) src = 0;
      else if (t_now - r1 < 0.05) src = 1;
      else src = 2;
      chk(src != 2, "R7 edge source", src, 0);
      if (src != 2) begin
        if (have_fall)
          chk(t_now - t_fall > 1.95, "R7 low phase x100ps", $rtoi((t_now - t_fall) * 100), 200);
        if (!busy) chk(src == int'(sel_active), "R2 idle source", src, int'(sel_active));
        if (prev_src >= 0 && src != prev_src)
          chk(since_fall[src] >= 6, "R6 quiet edges", since_fall[src], 6);
        prev_src = src; cur_src = src; rises_by[src]++; t_rise = t_now;
      end
    end
  end

  always @(negedge clk_out) begin
    if (mon_on && prev_src >= 0) begin
      chk((($realtime - t_rise) - half[cur_src]) < 0.05 && (half[cur_src] - ($realtime - t_rise)) < 0.05,
          "R7 high phase x100ps", $rtoi(($realtime - t_rise) * 100), $rtoi(half[cur_src] * 100));
      t_fall = $realtime; have_fall = 1'b1;
      since_fall[0] = 0; since_fall[1] = 0;
    end
  end

  task automatic wait_idle(input string req);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk0);
      if (!busy) break;
    end
    chk(!busy, req, int'(busy), 0);
  endtask

  task automatic switch_to(input logic v);
    int   c0;
    logic old;
    @(negedge clk0);
    old = sel_active; c0 = rises_by[0];
    sel = v;
    @(negedge clk0);
    chk(busy == 1'b1, "R4 busy rises", int'(busy), 1);
    chk(sel_active == old, "R4 active holds", int'(sel_active), int'(old));
    wait_idle("R4 switch completes");
    chk(sel_active == v, "R4 active updated", int'(sel_active), int'(v));
    if (old == 1'b0 && v == 1'b1)
      chk(rises_by[0] - c0 == 1, "R5 trailing ch0 pulses", rises_by[0] - c0, 1);
    repeat (30) @(negedge clk0);
  endtask

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int snap;
    repeat (4) @(negedge clk0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk0);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(sel_active == 1'b0, "R1 active after reset", int'(sel_active), 0);
    mon_on = 1'b1;
    repeat (20) @(negedge clk0);
    chk(rises_by[0] > 10 && rises_by[1] == 0, "R1 output from ch0", rises_by[1], 0);

    switch_to(1'b1);
    switch_to(1'b0);
    switch_to(1'b1);

    // R8: request back to 0 while switching to 1
    switch_to(1'b0);
    @(negedge clk0); sel = 1'b1;
    @(negedge clk0); sel = 1'b0;
    wait_idle("R8 first leg");
    chk(sel_active == 1'b1, "R8 first leg target", int'(sel_active), 1);
    @(negedge clk0);
    chk(busy == 1'b1, "R8 deferred switch starts", int'(busy), 1);
    wait_idle("R8 second leg");
    chk(sel_active == 1'b0, "R8 final channel", int'(sel_active), 0);
    repeat (30) @(negedge clk0);

    // R10: channel 1 stopped while switching 0 -> 1
    @(negedge clk0); sel = 1'b1; run1 = 1'b0;
    #100; snap = rises_by[0] + rises_by[1];
    #200;
    chk(busy == 1'b1, "R10 stall busy (to 1)", int'(busy), 1);
    chk(sel_active == 1'b0, "R10 stall active (to 1)", int'(sel_active), 0);
    chk(rises_by[0] + rises_by[1] == snap, "R10 output quiet", rises_by[0] + rises_by[1], snap);
    run1 = 1'b1;
    wait_idle("R10 resume (to 1)");
    chk(sel_active == 1'b1, "R10 completes to 1", int'(sel_active), 1);
    repeat (30) @(negedge clk0);

    // R10: channel 1 (old) stopped while switching 1 -> 0
    @(negedge clk0); sel = 1'b0; run1 = 1'b0;
    #300;
    chk(busy == 1'b1, "R10 stall busy (to 0)", int'(busy), 1);
    chk(sel_active == 1'b1, "R10 stall active (to 0)", int'(sel_active), 1);
    run1 = 1'b1;
    wait_idle("R10 resume (to 0)");
    chk(sel_active == 1'b0, "R10 completes to 0", int'(sel_active), 0);
    repeat (30) @(negedge clk0);

    // R9: control clock stopped, request must not act
    @(negedge clk0); run0 = 1'b0;
    #10; sel = 1'b1;
    #200;
    chk(busy == 1'b0, "R9 no start without ch0", int'(busy), 0);
    chk(sel_active == 1'b0, "R9 active held", int'(sel_active), 0);
    chk(rises_by[1] == 0 || prev_src == 0, "R9 output stays on ch0", prev_src, 0);
    run0 = 1'b1;
    #20;
    wait_idle("R9 resume");
    chk(sel_active == 1'b1, "R9 completes after restart", int'(sel_active), 1);
    repeat (40) @(negedge clk0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule